// File: doc/BRIEF.md
# Multi-Mode Pulse-Per-Second Output Generator

This block drives four pulse-per-second timing outputs from one fast timing clock. Each output channel has its own mode. A channel can copy a conditioned external 1 PPS pulse, regenerate that pulse with a programmed high time, or track the external pulse while it is judged valid and fall back to an internal flywheel when it is not. A channel can also run from the flywheel alone, forward one backplane sync line, or stay low.

The flywheel is a free-running counter with a programmed period and a programmed high time, both in ticks of the timing clock. Every valid rising edge of the external pulse resets the counter to zero. A channel that falls back therefore keeps the phase of the last good input edge. A host programs the block through a 32-bit register write port with four word addresses: control, mode configuration, flywheel period and flywheel high time. The flywheel rate select bit is held in the control register and brought out, so that the clock source outside the block can be switched between its 100 MHz and 160 MHz settings.

Top module: `pps_multimode_out`

## Requirements
- R1: While reset is asserted and after it is released, all four outputs are low and the rate select output is low.
- R2: While control bit 0 (enable, address 0) is clear, all outputs are low, the flywheel count is held at zero and every regenerated pulse is cancelled.
- R3: The mode word at address 1 holds a 3-bit code per channel, channel n in bits 3n+2 to 3n. The codes are: 0 follow, 1 follow with regenerated width, 2 auto-follow, 3 auto-follow with regenerated width, 4 flywheel, 5 sync pass-through, 6 off, 7 off.
- R4: In follow mode an output equals the external pulse one clock later, whatever the validity flag says.
- R5: In follow-with-width mode, a rising input edge seen while no pulse is active makes the output high for exactly H cycles, where H is the high-time register (address 3). The output goes high two clocks after the edge is sampled. Edges that arrive during an active pulse are ignored.
- R6: In auto-follow mode the output follows the external pulse one clock later while the validity flag is high, and equals the flywheel level one clock later while it is low.
- R7: In auto-follow-with-width mode the output is the regenerated pulse while the validity flag is high, and the flywheel level while it is low. Only edges that arrive while the flag is high start a pulse.
- R8: The flywheel count runs from 0 to P-1 and wraps, where P is the period register (address 2). The flywheel level is high while the count is below H.
- R9: A rising external edge with the validity flag high resets the flywheel count to zero on that clock, which phase-aligns the flywheel to the input.
- R10: In pass-through mode an output equals its own sync line one clock later.
- R11: Mode codes 6 and 7 hold the output low.
- R12: Control bit 1 (address 0) drives the rate select output one clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address |
| wr_data | input | 32 | Register write data |
| pps_in | input | 1 | Conditioned external pulse |
| pps_ok | input | 1 | External pulse validity flag |
| sync_in | input | 4 | Backplane sync lines, one per channel |
| pps_out | output | 4 | Channel outputs |
| fw_rate_sel | output | 1 | Flywheel clock rate select to the clock source |

## Verification
The hardest case to reach is an auto-follow channel that keeps the flywheel phase after the validity flag drops. A regenerated pulse that is still counting while the flag toggles is just as hard. The stimulus keeps the period short and sends valid edges at uneven spacings, then lowers the flag in the middle of a pulse. It also shrinks the period register below the current count while the flywheel runs. A behavioural per-cycle model is compared on every channel each clock, and bursts of closely spaced edges probe the rule that a running pulse is not retriggered.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [2:0] {
    M_FOLLOW   = 3'd0,
    M_FOLLOW_W = 3'd1,
    M_AUTO     = 3'd2,
    M_AUTO_W   = 3'd3,
    M_FLY      = 3'd4,
    M_PASS     = 3'd5,
    M_OFF      = 3'd6,
    M_OFF_ALT  = 3'd7
  } pps_mode_e;

  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_MODES  = 2'd1;
  localparam logic [1:0] A_PERIOD = 2'd2;
  localparam logic [1:0] A_HIGH   = 2'd3;
  localparam int MODE_W = 3;

  // wrap when the next count would reach the period
  function automatic logic fw_wrap(input logic [31:0] cnt, input logic [31:0] period);
    return ({1'b0, cnt} + 33'd1) >= {1'b0, period};
  endfunction

  function automatic logic fw_level(input logic [31:0] cnt, input logic [31:0] high);
    return cnt < high;
  endfunction
endpackage

// File: rtl/pps_regs.sv
module pps_regs
  import pps_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int CNT_W      = 32,
  parameter int RST_PERIOD = 100_000_000,
  parameter int RST_HIGH   = 2000,
  localparam int CFG_W     = NCH * MODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  output logic             en,
  output logic             rate,
  output logic [CFG_W-1:0] cfg,
  output logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] high
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      rate   <= 1'b0;
      cfg    <= '0;
      period <= CNT_W'(RST_PERIOD);
      high   <= CNT_W'(RST_HIGH);
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:   begin en <= wr_data[0]; rate <= wr_data[1]; end
        A_MODES:  cfg    <= wr_data[CFG_W-1:0];
        A_PERIOD: period <= wr_data[CNT_W-1:0];
        default:  high   <= wr_data[CNT_W-1:0];
      endcase
    end
  end

  // R12
  rate_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL) |=> (rate == $past(wr_data[1])));
endmodule

// File: rtl/pps_flywheel.sv
module pps_flywheel
  import pps_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             align,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] high,
  output logic             fw_hi
);
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap  = fw_wrap(32'(cnt), 32'(period));
  assign fw_hi = fw_level(32'(cnt), 32'(high));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!en || align)    cnt <= '0;
    else if (wrap)            cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  // R9
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && align) |=> (cnt == '0));
  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !align && wrap) |=> (cnt == '0));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
endmodule

// File: rtl/pps_chan.sv
module pps_chan
  import pps_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [2:0]       mode,
  input  logic             pps_in,
  input  logic             pps_ok,
  input  logic             rise,
  input  logic             fw_hi,
  input  logic             sync,
  input  logic [CNT_W-1:0] high,
  output logic             out_q
);
  pps_mode_e        md;
  logic [CNT_W-1:0] rem;
  logic             trig;
  logic             busy;
  logic             lvl;

  assign md   = pps_mode_e'(mode);
  assign busy = (rem != '0);
  assign trig = rise && (md == M_FOLLOW_W || (md == M_AUTO_W && pps_ok));

  always_comb begin
    case (md)
      M_FOLLOW:   lvl = pps_in;
      M_FOLLOW_W: lvl = busy;
      M_AUTO:     lvl = pps_ok ? pps_in : fw_hi;
      M_AUTO_W:   lvl = pps_ok ? busy : fw_hi;
      M_FLY:      lvl = fw_hi;
      M_PASS:     lvl = sync;
      default:    lvl = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rem <= '0;
    else if (!en)            rem <= '0;
    else if (!busy && trig)  rem <= high;
    else if (busy)           rem <= rem - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= en & lvl;
  end

  // R4
  follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && md == M_FOLLOW) |=> (out_q == $past(pps_in)));
  // R10
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && md == M_PASS) |=> (out_q == $past(sync)));
  // R11
  off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || md == M_OFF || md == M_OFF_ALT) |=> !out_q);
  // R6
  fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && md == M_AUTO && !pps_ok) |=> (out_q == $past(fw_hi)));
  // R5
  no_retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && busy && trig) |=> (rem == $past(rem) - 1'b1));
endmodule

// File: rtl/pps_multimode_out.sv
module pps_multimode_out
  import pps_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int CNT_W      = 32,
  parameter int RST_PERIOD = 100_000_000,
  parameter int RST_HIGH   = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        pps_in,
  input  logic        pps_ok,
  input  logic [3:0]  sync_in,
  output logic [3:0]  pps_out,
  output logic        fw_rate_sel
);
  localparam int CFG_W = NCH * MODE_W;

  logic             en;
  logic [CFG_W-1:0] cfg;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] high;
  logic             pin_q;
  logic             rise;
  logic             align;
  logic             fw_hi;

  pps_regs #(.NCH(NCH), .CNT_W(CNT_W), .RST_PERIOD(RST_PERIOD), .RST_HIGH(RST_HIGH)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en(en), .rate(fw_rate_sel), .cfg(cfg), .period(period), .high(high)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pps_in;
  end

  assign rise  = pps_in & ~pin_q;
  assign align = rise & pps_ok;

  pps_flywheel #(.CNT_W(CNT_W)) fly_i (
    .clk(clk), .rst_n(rst_n), .en(en), .align(align),
    .period(period), .high(high), .fw_hi(fw_hi)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pps_chan #(.CNT_W(CNT_W)) chan_i (
      .clk(clk), .rst_n(rst_n), .en(en),
      .mode(cfg[ch*MODE_W +: MODE_W]),
      .pps_in(pps_in), .pps_ok(pps_ok), .rise(rise), .fw_hi(fw_hi),
      .sync(sync_in[ch]), .high(high), .out_q(pps_out[ch])
    );
  end

  // R2
  all_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pps_out == '0));
endmodule

// File: tb/pps_multimode_out_tb_top.sv
module pps_multimode_out_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        pps_in = 1'b0;
  logic        pps_ok = 1'b0;
  logic [3:0]  sync_in = '0;
  logic [3:0]  pps_out;
  logic        fw_rate_sel;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pps_multimode_out dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pps_in(pps_in), .pps_ok(pps_ok), .sync_in(sync_in),
    .pps_out(pps_out), .fw_rate_sel(fw_rate_sel)
  );

  // behavioural reference model
  bit          m_en, m_rate, m_pinq;
  int unsigned m_cfg, m_p, m_h, m_cnt;
  int unsigned m_rem [4];
  bit          m_out [4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_rate = 0; m_pinq = 0; m_cfg = 0;
      m_p = 100_000_000; m_h = 2000; m_cnt = 0;
      for (int c = 0; c < 4; c++) begin m_rem[c] = 0; m_out[c] = 0; end
    end else begin
      bit r, fh;
      r  = pps_in && !m_pinq;
      fh = m_cnt < m_h;
      for (int c = 0; c < 4; c++) begin
        int md;
        bit t, lv;
        md = (m_cfg >> (3 * c)) & 7;
        t  = r && (md == 1 || (md == 3 && pps_ok));
        case (md)
          0: lv = pps_in;
          1: lv = m_rem[c] != 0;
          2: lv = pps_ok ? pps_in : fh;
          3: lv = pps_ok ? (m_rem[c] != 0) : fh;
          4: lv = fh;
          5: lv = sync_in[c];
          default: lv = 0;
        endcase
        m_out[c] = m_en && lv;
        if (!m_en) m_rem[c] = 0;
        else if (m_rem[c] == 0 && t) m_rem[c] = m_h;
        else if (m_rem[c] != 0) m_rem[c] = m_rem[c] - 1;
      end
      if (!m_en || (r && pps_ok)) m_cnt = 0;
      else if (longint'(m_cnt) + 1 >= longint'(m_p)) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      m_pinq = pps_in;
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin m_en = wr_data[0]; m_rate = wr_data[1]; end
          2'd1: m_cfg = wr_data & 32'hFFF;
          2'd2: m_p = wr_data;
          default: m_h = wr_data;
        endcase
      end
    end
  end

  function automatic string req_tag(int md, bit en);
    if (!en) return "R2";
    case (md)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8/R9";
      5: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check_bit(string tag, bit act, bit exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every channel against the model (mode field per R3)
  task automatic compare_all();
    for (int c = 0; c < 4; c++)
      check_bit($sformatf("%s ch%0d (mode field R3)", req_tag((m_cfg >> (3 * c)) & 7, m_en), c),
                pps_out[c], m_out[c]);
    check_bit("R12", fw_rate_sel, m_rate);
  endtask

  int unsigned lfsr = 32'h1ACE;
  task automatic step();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    sync_in = lfsr[3:0];
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic pulse(int hi, int lo, bit ok);
    pps_ok = ok;
    pps_in = 1'b1;
    for (int i = 0; i < hi; i++) step();
    pps_in = 1'b0;
    for (int i = 0; i < lo; i++) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_bit("R1 out", pps_out != 0, 1'b0);
    check_bit("R1 rate", fw_rate_sel, 1'b0);
    rst_n = 1'b1;
    step();
    check_bit("R1 after release", pps_out != 0, 1'b0);

    wr(2'd2, 32'd20);
    wr(2'd3, 32'd5);
    // R2: modes set but enable clear, every output stays low
    wr(2'd1, {20'd0, 3'd5, 3'd4, 3'd2, 3'd0});
    pulse(3, 6, 1'b1);
    pulse(8, 4, 1'b0);
    check_bit("R2 idle", pps_out != 0, 1'b0);

    // R12: enable and rate select
    wr(2'd0, 32'h3);
    check_bit("R12 rate high", fw_rate_sel, 1'b1);

    // follow, follow-width, auto, pass
    wr(2'd1, {20'd0, 3'd5, 3'd2, 3'd1, 3'd0});
    pulse(2, 9, 1'b1);
    pulse(1, 1, 1'b1);   // R5: retrigger attempts during a pulse
    pulse(1, 7, 1'b1);
    pulse(9, 3, 1'b1);
    pulse(3, 30, 1'b0);  // R6: flywheel fallback
    pulse(2, 13, 1'b1);  // R9: realign
    for (int k = 0; k < 12; k++) pulse(1 + (k % 4), 3 + (k * 5) % 17, k % 3 != 0);

    // auto-width, flywheel, off, off-alt
    wr(2'd1, {20'd0, 3'd7, 3'd6, 3'd4, 3'd3});
    for (int k = 0; k < 14; k++) pulse(1 + (k % 3), 2 + (k * 7) % 19, k % 4 != 1);
    pps_ok = 1'b1; pps_in = 1'b1;
    step(); step();
    pps_ok = 1'b0;       // R7: flag drops mid pulse
    for (int i = 0; i < 25; i++) step();
    pps_in = 1'b0;

    // R8: shrink period below the running count
    wr(2'd1, {20'd0, 3'd4, 3'd4, 3'd3, 3'd2});
    for (int i = 0; i < 15; i++) step();
    wr(2'd2, 32'd7);
    wr(2'd3, 32'd3);
    for (int i = 0; i < 30; i++) step();
    pulse(1, 10, 1'b1);
    wr(2'd2, 32'd0);
    for (int i = 0; i < 6; i++) step();

    // R11 via pass/off mix and R2 disable mid run
    wr(2'd2, 32'd11);
    wr(2'd1, {20'd0, 3'd6, 3'd5, 3'd0, 3'd1});
    pulse(4, 8, 1'b1);
    wr(2'd0, 32'h0);
    pulse(4, 8, 1'b1);
    check_bit("R2 disabled", pps_out != 0, 1'b0);
    check_bit("R12 rate low", fw_rate_sel, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100_000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule